// File: doc/BRIEF.md
# Four-Phase Handshake Bus Initiator

This block is the only master on a small parallel bus whose target runs without a clock. The bus carries an address, a data path, a direction line and two active-low strobes: a request strobe that the initiator drives and an acknowledge strobe that the target drives. A local client hands the block one command at a time through a valid/ready pair. The command is a read or a write, an address and, for a write, a data byte. The block then runs a return-to-idle four-phase exchange on the bus and reports the end with a one-cycle done pulse. On a read, the captured byte comes with that pulse.

The shared data wires appear at the ports as a separate output value, an input value and an output enable. The address and direction lines have their own enable. The acknowledge strobe is asynchronous to the block, so it passes through a chain of flops before any decision uses it. The reset input is asserted asynchronously and released in step with the clock.

Top module: `hs_bus_master`

## Requirements
- R1: While the address enable is high, `bus_cmd` is 0 for a read command and 1 for a write command, and `bus_addr` holds the accepted address.
- R2: Address, direction and (for a write) data are driven with their enables for at least one clock before `bus_req_n` goes low, and they stay stable while `bus_req_n` is low.
- R3: `bus_req_n` goes low on the second rising edge after the command is accepted, and stays low until the synchronized acknowledge is seen low.
- R4: On a read, the byte on `bus_data_in` is captured on the edge where the synchronized acknowledge is first seen low, never earlier, and is presented on `rdata` while `done` is high.
- R5: On the edge where the synchronized acknowledge is first seen low, `bus_req_n` returns high and every bus output enable goes low.
- R6: `bus_data_oe` is high only during a write, together with the address enable, with `bus_data_out` equal to the accepted write byte.
- R7: `done` is a single-cycle pulse that rises only after the synchronized acknowledge has returned high following the release of `bus_req_n`.
- R8: `cmd_ready` is high only when the block is idle and out of reset; a `cmd_valid` seen while `cmd_ready` is low has no effect on the bus lines.
- R9: `bus_ack_n` passes through two flops: after a change of `bus_ack_n` between two edges, the state machine reacts on the third rising edge.
- R10: While reset is held, and for two edges after its release, `bus_req_n` is high, both enables are low, `done` is low and `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Initiator clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cmd_valid | input | 1 | Local command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Target address |
| cmd_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with done on a read |
| bus_addr | output | 8 | Bus address value |
| bus_addr_oe | output | 1 | Enable for address and direction lines |
| bus_cmd | output | 1 | Direction line, 0 read, 1 write |
| bus_data_out | output | 8 | Data value driven on writes |
| bus_data_oe | output | 1 | Enable for the data lines |
| bus_data_in | input | 8 | Data value seen on the bus |
| bus_req_n | output | 1 | Active-low request strobe |
| bus_ack_n | input | 1 | Active-low acknowledge from the target |

## Verification
A state machine stuck in or skipping a phase shows at once on the strobe and enable ports. For example, an early return to idle raises `cmd_ready` and pulses `done` while the acknowledge is still low, and the per-clock reference comparison catches this within the same cycle. A capture taken at the wrong moment shows up only at the end of the transaction, as a wrong `rdata` with `done`. The bench therefore holds the data lines at a decoy value until the acknowledge falls, and changes them again as soon as the request rises. A synchronizer of the wrong depth moves the rising edge of `bus_req_n` by one clock, and the cycle compare reports this on the first transaction.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_REQ     = 2'd2,
    ST_RELEASE = 2'd3
  } hsb_state_e;
endpackage

// File: rtl/hsb_rst_sync.sv
module hsb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = chain_q[STAGES-1];
endmodule

// File: rtl/hsb_ack_sync.sv
module hsb_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ack_n_async,
  output logic ack_n_sync
);
  logic [STAGES-1:0] flop_q;

  // idle level of the strobe is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flop_q <= '1;
    else         flop_q <= {flop_q[STAGES-2:0], ack_n_async};
  end

  assign ack_n_sync = flop_q[STAGES-1];
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
  import hsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       start,
  input  logic       ack_n_sync,
  output hsb_state_e state,
  output logic       load_en,
  output logic       cap_en,
  output logic       req_n,
  output logic       oe,
  output logic       done
);
  hsb_state_e state_q, state_d;
  logic       req_n_q, oe_q, done_q;
  logic       req_n_d, oe_d, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_SETUP;
      ST_SETUP:   state_d = ST_REQ;
      ST_REQ:     if (!ack_n_sync) state_d = ST_RELEASE;
      ST_RELEASE: if (ack_n_sync) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    req_n_d = (state_d != ST_REQ);
    oe_d    = (state_d == ST_SETUP) || (state_d == ST_REQ);
    done_d  = (state_q == ST_RELEASE) && (state_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_n_q <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_n_q <= req_n_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  assign state   = state_q;
  assign load_en = (state_q == ST_IDLE) && start;
  assign cap_en  = (state_q == ST_REQ) && !ack_n_sync;
  assign req_n   = req_n_q;
  assign oe      = oe_q;
  assign done    = done_q;
endmodule

// File: rtl/hsb_dpath.sv
module hsb_dpath #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_en,
  input  logic              cap_en,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] bus_rd,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rd_cap;

  assign rd_cap = cap_en && !wr_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      wr_q    <= in_write;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_cap) rdata_q <= bus_rd;
  end

  assign is_write = wr_q;
  assign addr     = addr_q;
  assign wdata    = wdata_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/hs_bus_master.sv
module hs_bus_master
  import hsb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic              bus_cmd,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic              bus_req_n,
  input  logic              bus_ack_n
);
  logic       rst_ni;
  logic       ack_s;
  logic       start, load_en, cap_en, oe, is_write;
  hsb_state_e state;

  hsb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  hsb_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .ack_n_async (bus_ack_n),
    .ack_n_sync  (ack_s)
  );

  assign cmd_ready = rst_ni && (state == ST_IDLE);
  assign start     = cmd_valid && cmd_ready;

  hsb_fsm u_fsm (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .start      (start),
    .ack_n_sync (ack_s),
    .state      (state),
    .load_en    (load_en),
    .cap_en     (cap_en),
    .req_n      (bus_req_n),
    .oe         (oe),
    .done       (done)
  );

  hsb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load_en  (load_en),
    .cap_en   (cap_en),
    .in_write (cmd_write),
    .in_addr  (cmd_addr),
    .in_wdata (cmd_wdata),
    .bus_rd   (bus_data_in),
    .is_write (is_write),
    .addr     (bus_addr),
    .wdata    (bus_data_out),
    .rdata    (rdata)
  );

  assign bus_cmd     = is_write;
  assign bus_addr_oe = oe;
  assign bus_data_oe = oe && is_write;
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_n,
  input logic              addr_oe,
  input logic              data_oe,
  input logic              bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              done,
  input logic              cmd_ready,
  input logic              ack_s
);
  AST_REQ_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> addr_oe); // R2

  AST_SETUP_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $past(addr_oe)); // R2

  AST_LINES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && $past(!req_n)) |-> ($stable(bus_addr) && $stable(bus_cmd))); // R2

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && ack_s) |=> !req_n); // R3

  AST_RELEASE_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> (!addr_oe && !data_oe)); // R5

  AST_DATA_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (bus_cmd && addr_oe)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_n && !addr_oe)); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (req_n && !addr_oe)); // R8
endmodule

bind hs_bus_master hsb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_n     (bus_req_n),
  .addr_oe   (bus_addr_oe),
  .data_oe   (bus_data_oe),
  .bus_cmd   (bus_cmd),
  .bus_addr  (bus_addr),
  .done      (done),
  .cmd_ready (cmd_ready),
  .ack_s     (ack_s)
);

// File: tb/hs_bus_master_tb_top.sv
`timescale 1ns/1ps
module hs_bus_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [7:0] cmd_addr = 8'h00, cmd_wdata = 8'h00;
  logic       cmd_ready, done, bus_addr_oe, bus_cmd, bus_data_oe, bus_req_n;
  logic [7:0] rdata, bus_addr, bus_data_out;
  logic [7:0] bus_data_in = 8'h3C;
  logic       bus_ack_n = 1'b1;

  int checks = 0, fails = 0;
  int d_ack = 2, d_rel = 1;
  bit finished = 0, cmp_on = 0;
  logic [7:0] tmem [256];
  logic [7:0] shadow [256];

  always #4 clk = ~clk;

  hs_bus_master dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
    .bus_cmd(bus_cmd), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_data_in(bus_data_in), .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: phase number, two-deep acknowledge history
  int   m_st, m_rel;
  logic m_a1, m_a2, m_reqn, m_oe, m_done, m_wr;
  logic [7:0] m_addr, m_wd, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rel = 0; m_a1 = 1; m_a2 = 1; m_reqn = 1; m_oe = 0; m_done = 0;
      m_wr = 0; m_addr = 0; m_wd = 0; m_rd = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      logic seen;
      seen = m_a2;
      m_a2 = m_a1;
      m_a1 = bus_ack_n;
      m_done = 0;
      case (m_st)
        0: if (cmd_valid) begin
             m_st = 1; m_oe = 1; m_wr = cmd_write; m_addr = cmd_addr; m_wd = cmd_wdata;
           end
        1: begin m_st = 2; m_reqn = 0; end
        2: if (!seen) begin
             m_st = 3; m_reqn = 1; m_oe = 0;
             if (!m_wr) m_rd = bus_data_in;
           end
        default: if (seen) begin m_st = 0; m_done = 1; end
      endcase
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk(bus_req_n === m_reqn, "R3/R5/R9 req_n", bus_req_n, m_reqn);
    chk(bus_addr_oe === m_oe, "R2/R5 addr_oe", bus_addr_oe, m_oe);
    chk(bus_data_oe === (m_oe && m_wr), "R6 data_oe", bus_data_oe, m_oe && m_wr);
    chk(done === m_done, "R7 done", done, m_done);
    chk(cmd_ready === (m_st == 0 && m_rel >= 2), "R8/R10 cmd_ready", cmd_ready, m_st == 0 && m_rel >= 2);
    if (m_oe) begin
      chk(bus_addr === m_addr, "R1 bus_addr", bus_addr, m_addr);
      chk(bus_cmd === m_wr, "R1 bus_cmd", bus_cmd, m_wr);
    end
    if (m_oe && m_wr) chk(bus_data_out === m_wd, "R6 data_out", bus_data_out, m_wd);
    if (m_done && !m_wr) chk(rdata === m_rd, "R4 rdata", rdata, m_rd);
  end

  // clockless target model, sampled on falling edges
  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'((i * 7) + 1);
    forever begin
      @(negedge clk);
      if (rst_n && !bus_req_n) begin
        repeat (d_ack) @(negedge clk);
        if (bus_cmd) tmem[bus_addr] = bus_data_out;
        else         bus_data_in = tmem[bus_addr];
        bus_ack_n = 1'b0;
        while (!bus_req_n) @(negedge clk);
        bus_data_in = 8'h3C;
        repeat (d_rel) @(negedge clk);
        bus_ack_n = 1'b1;
      end
    end
  end

  task automatic txn(input bit wr, input logic [7:0] a, input logic [7:0] d, input bit busy_poke);
    int ack_lag, rel_lag;
    cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (wr) shadow[a] = d;
    if (busy_poke) begin
      cmd_valid = 1'b1; cmd_write = ~wr; cmd_addr = ~a; cmd_wdata = 8'hEE;
      repeat (2) begin
        chk(cmd_ready === 1'b0, "R8 ready low while busy", cmd_ready, 0);
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    // R3: request low one edge after the enables came up
    chk(bus_req_n === (busy_poke ? 1'b0 : 1'b1), "R3 req_n before request edge", bus_req_n, busy_poke ? 0 : 1);
    while (bus_ack_n) @(negedge clk);
    ack_lag = 0;
    while (!bus_req_n) begin @(negedge clk); ack_lag++; end
    chk(ack_lag == 3, "R9 request release lag", ack_lag, 3);
    rel_lag = 0;
    while (!done) begin
      @(negedge clk); rel_lag++;
      if (!done) chk(bus_addr_oe === 1'b0, "R5 enables off after release", bus_addr_oe, 0);
    end
    chk(rel_lag >= d_rel + 3, "R7 done after acknowledge high", rel_lag, d_rel + 3);
    if (!wr) chk(rdata === shadow[a], "R4 read value", rdata, shadow[a]);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'((i * 7) + 1);
    repeat (3) @(negedge clk);
    cmp_on = 1;
    chk(bus_req_n === 1'b1, "R10 reset req_n", bus_req_n, 1);
    chk(bus_addr_oe === 1'b0 && bus_data_oe === 1'b0, "R10 reset enables", bus_addr_oe, 0);
    chk(done === 1'b0, "R10 reset done", done, 0);
    rst_n = 1'b1;
    chk(cmd_ready === 1'b0, "R10 ready after release", cmd_ready, 0);
    @(negedge clk);
    chk(cmd_ready === 1'b0, "R10 ready one edge after release", cmd_ready, 0);
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R10 ready two edges after release", cmd_ready, 1);
    txn(0, 8'h24, 8'h00, 0);
    txn(1, 8'h31, 8'hF4, 0);
    txn(0, 8'h31, 8'h00, 0);
    d_ack = 0; d_rel = 0;
    txn(1, 8'hFF, 8'h5A, 0);
    txn(0, 8'hFF, 8'h00, 0);
    d_ack = 5; d_rel = 8;
    txn(0, 8'h00, 8'h00, 1);
    txn(1, 8'h80, 8'h01, 1);
    txn(0, 8'h80, 8'h00, 0);
    d_ack = 1; d_rel = 3;
    for (int k = 0; k < 6; k++) txn(k[0], 8'(k * 37), 8'(k * 11 + 3), 0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule